// File: doc/BRIEF.md
# Push-Pull Fault Retry and Soft-Start Sequencer

This block decides when a push-pull pulse generator may switch and when its oscillator synchronization pulse may be sent out. It watches three inputs: a one-clock strobe for each oscillator cycle, a supply-good flag whose hysteresis has already been applied, and a raw overcurrent flag. From these it drives an enable for the power outputs, an enable for the SYNC pulse, and a per-cycle duty-step index. The pulse generator turns that index into a leading-edge delay.

When the supply becomes good, and again after every overcurrent fault, the sequencer holds everything off for a fixed number of oscillator cycles. It then lets SYNC run alone for a lead-in cycle. After that it opens the outputs with a stepped leading-edge soft start. An overcurrent cuts both enables within the same clock. A loss of supply does the same and sends the machine back to the start of the full sequence. All sequencing counts oscillator strobes, not clock cycles, so every delay scales with the programmed switching frequency.

Top module: `pp_restart_seq`

## Requirements
- R1: After reset, with the supply flag low, `out_en_o` and `sync_en_o` are 0 and `duty_step_o` is 0.
- R2: While `ovc_i` is 1, `out_en_o` and `sync_en_o` are 0 in the same clock cycle, with no wait for a strobe or a clock edge.
- R3: After the supply flag goes high, or after the synchronized overcurrent flag reads low again, both enables stay 0 for the first 55 cycle strobes.
- R4: If an overcurrent occurs during the hold-off, the hold-off starts over. A full 56 further strobes are needed once the flag reads low again.
- R5: At the 56th hold-off strobe, `sync_en_o` goes to 1 while `out_en_o` and `duty_step_o` stay 0 for exactly one more strobe (the SYNC lead-in).
- R6: Soft start: at the strobe that ends the lead-in, `out_en_o` goes to 1 with `duty_step_o` = 1. Each later strobe raises the index by 1, up to 7. Index n means a leading-edge delay of (7-n)/7 of the charge interval, and 7 means the full pulse. Between strobes the index never moves by more than 1.
- R7: At the 64th strobe of the sequence the block enters the run state. `duty_step_o` then stays at 7 and both enables stay 1 on every later strobe.
- R8: While the supply flag is 0, both enables are 0 in the same cycle. When the flag returns, the full 64-strobe sequence runs again from the start.
- R9: Whenever neither enable is 1 and no fault or supply input forces them low, `duty_step_o` is 0.
- R10: Clock cycles without a strobe do not advance the hold-off, the lead-in or the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick_i | input | 1 | One-clock strobe per oscillator cycle |
| supply_ok_i | input | 1 | Supply-good flag, hysteresis already applied |
| ovc_i | input | 1 | Raw overcurrent flag, asynchronous |
| out_en_o | output | 1 | Permits the push-pull output pulses |
| sync_en_o | output | 1 | Permits the SYNC pulse |
| duty_step_o | output | 3 | Soft-start step index, 0 when off, 1 to 7 |

## Verification
The sequence is driven from four starting points: supply power-up, an overcurrent during run, an overcurrent part-way through the hold-off, and an overcurrent during the SYNC lead-in. A supply drop in the middle of the ramp is driven as well. Counting strobes from each start separates a hold-off that restarts from one that resumes, and it separates a lead-in of one cycle from none. The bench samples the enables just after the fault input changes, before any clock edge, which shows that the kill path is combinational. A long gap with no strobes inside the hold-off shows that only strobes move the counter.

// File: rtl/prs_pkg.sv
`timescale 1ns/1ps
package prs_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HOLD = 3'd1,
    ST_LEAD = 3'd2,
    ST_RAMP = 3'd3,
    ST_RUN  = 3'd4
  } prs_state_e;

endpackage

// File: rtl/prs_sync2.sv
`timescale 1ns/1ps
module prs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/prs_cycle_cnt.sv
`timescale 1ns/1ps
module prs_cycle_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != TOP));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/prs_step_ramp.sv
`timescale 1ns/1ps
module prs_step_ramp #(
  parameter int STEPS = 7,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] step_o,
  output logic         top_o
);

  localparam logic [W-1:0] LAST  = W'(STEPS);
  localparam logic [W-1:0] FIRST = W'(1);

  logic [W-1:0] step_q;
  logic [W-1:0] step_d;
  logic         step_en;

  always_comb begin
    step_d  = step_q;
    step_en = 1'b0;
    if (clr_i) begin
      step_d  = '0;
      step_en = 1'b1;
    end else if (load_i) begin
      step_d  = FIRST;
      step_en = 1'b1;
    end else if (inc_i && (step_q != LAST)) begin
      step_d  = step_q + 1'b1;
      step_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign step_o = step_q;
  assign top_o  = (step_q == LAST);

endmodule

// File: rtl/pp_restart_seq.sv
`timescale 1ns/1ps
module pp_restart_seq #(
  parameter int  HOLD_CYC   = 56,
  parameter int  LEAD_CYC   = 1,
  parameter int  RAMP_STEPS = 7,
  localparam int STEP_W     = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick_i,
  input  logic              supply_ok_i,
  input  logic              ovc_i,
  output logic              out_en_o,
  output logic              sync_en_o,
  output logic [STEP_W-1:0] duty_step_o
);

  import prs_pkg::*;

  localparam int CNT_MAX = (HOLD_CYC > LEAD_CYC) ? HOLD_CYC : LEAD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);

  prs_state_e        state_q;
  prs_state_e        state_d;
  logic              ovc_s;
  logic [CNT_W-1:0]  cyc_cnt;
  logic              cnt_clr;
  logic [STEP_W-1:0] ramp_step;
  logic              ramp_top;
  logic              ramp_clr;
  logic              ramp_load;
  logic              ramp_inc;
  logic              lead_on;
  logic              drive_on;

  // overcurrent enters the sequencing through a two-flop synchronizer
  prs_sync2 u_ovc_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ovc_i),
    .sync_o  (ovc_s)
  );

  // next-state logic: supply loss outranks fault, fault outranks progress
  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else if (ovc_s) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_HOLD;
        ST_HOLD: if (cyc_tick_i && (cyc_cnt == HOLD_LAST)) state_d = ST_LEAD;
        ST_LEAD: if (cyc_tick_i && (cyc_cnt == LEAD_LAST)) state_d = ST_RAMP;
        ST_RAMP: if (cyc_tick_i && ramp_top) state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  // shared strobe counter for hold-off and lead-in; restarts on every
  // state change and is held at zero while a fault or supply loss persists
  always_comb begin
    cnt_clr = (state_d != state_q) || ovc_s || !supply_ok_i;
  end

  prs_cycle_cnt #(.W(CNT_W)) u_cyc_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cyc_tick_i),
    .count_o (cyc_cnt)
  );

  // soft-start step index
  always_comb begin
    ramp_clr  = (state_d == ST_OFF) || (state_d == ST_HOLD) ||
                (state_d == ST_LEAD);
    ramp_load = (state_d == ST_RAMP) && (state_q != ST_RAMP);
    ramp_inc  = (state_q == ST_RAMP) && cyc_tick_i;
  end

  prs_step_ramp #(.STEPS(RAMP_STEPS), .W(STEP_W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ramp_clr),
    .load_i (ramp_load),
    .inc_i  (ramp_inc),
    .step_o (ramp_step),
    .top_o  (ramp_top)
  );

  // outputs: state-derived permission, cut combinationally by the raw
  // fault and supply inputs so shutdown needs no clock edge
  always_comb begin
    lead_on  = (state_q == ST_LEAD) || (state_q == ST_RAMP) ||
               (state_q == ST_RUN);
    drive_on = (state_q == ST_RAMP) || (state_q == ST_RUN);
    sync_en_o = lead_on && supply_ok_i && !ovc_i;
    out_en_o  = drive_on && supply_ok_i && !ovc_i;
    if (state_q == ST_RUN) begin
      duty_step_o = STEP_W'(RAMP_STEPS);
    end else if (state_q == ST_RAMP) begin
      duty_step_o = ramp_step;
    end else begin
      duty_step_o = '0;
    end
  end

endmodule

// File: rtl/pp_restart_seq_chk.sv
`timescale 1ns/1ps
module pp_restart_seq_chk #(
  parameter int HOLD_CYC = 56,
  parameter int STEP_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_tick_i,
  input logic              supply_ok_i,
  input logic              ovc_i,
  input logic              out_en_o,
  input logic              sync_en_o,
  input logic [STEP_W-1:0] duty_step_o
);

  localparam int QW = $clog2(HOLD_CYC + 2);
  localparam logic [QW-1:0] QTOP = {QW{1'b1}};
  localparam logic [QW-1:0] QHOLD = QW'(HOLD_CYC);

  // strobes seen while SYNC is off and no fault or supply loss is present
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (!supply_ok_i || ovc_i || sync_en_o) begin
      quiet_q <= '0;
    end else if (cyc_tick_i && (quiet_q != QTOP)) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  a_r2_fault_kills: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_i |-> (!out_en_o && !sync_en_o));

  a_r8_supply_kills: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |-> (!out_en_o && !sync_en_o));

  a_r3_holdoff_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en_o) |-> (quiet_q >= QHOLD));

  a_r5_sync_leads: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> sync_en_o);

  a_r6_step_rate: assert property (@(posedge clk) disable iff (!rst_n)
    ((duty_step_o != '0) && ($past(duty_step_o) != '0)) |->
      ((duty_step_o == $past(duty_step_o)) ||
       (duty_step_o == $past(duty_step_o) + 1'b1)));

  a_r9_idle_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en_o && supply_ok_i && !ovc_i) |-> (duty_step_o == '0));

  a_r10_no_strobe_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_tick_i && (duty_step_o != '0) && supply_ok_i && !ovc_i) |=>
      ((duty_step_o == $past(duty_step_o)) || (duty_step_o == '0)));

endmodule

bind pp_restart_seq pp_restart_seq_chk #(
  .HOLD_CYC (HOLD_CYC),
  .STEP_W   (STEP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_tick_i  (cyc_tick_i),
  .supply_ok_i (supply_ok_i),
  .ovc_i       (ovc_i),
  .out_en_o    (out_en_o),
  .sync_en_o   (sync_en_o),
  .duty_step_o (duty_step_o)
);

// File: tb/pp_restart_seq_test.sv
`timescale 1ns/1ps
module pp_restart_seq_test;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       sup_ok;
  logic       ovc;
  logic       out_en;
  logic       sync_en;
  logic [2:0] duty;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pp_restart_seq uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_tick_i  (tick),
    .supply_ok_i (sup_ok),
    .ovc_i       (ovc),
    .out_en_o    (out_en),
    .sync_en_o   (sync_en),
    .duty_step_o (duty)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one oscillator strobe; returns at the negedge after the registering edge
  task automatic strobe();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // full restart sequence from a freshly entered hold-off
  task automatic run_seq(input string tag, input int idle_at);
    for (int k = 1; k <= 67; k++) begin
      strobe();
      if (k < 56) begin
        chk({tag, " R3 sync off in hold-off"}, sync_en, 0);
        chk({tag, " R3 outputs off in hold-off"}, out_en, 0);
        if (k == idle_at) begin
          idle(60);
          chk({tag, " R10 no strobe keeps sync off"}, sync_en, 0);
          chk({tag, " R10 no strobe keeps step zero"}, duty, 0);
        end
      end else if (k == 56) begin
        chk({tag, " R5 sync on after hold-off"}, sync_en, 1);
        chk({tag, " R5 outputs still off in lead-in"}, out_en, 0);
        chk({tag, " R9 step zero in lead-in"}, duty, 0);
      end else if (k <= 63) begin
        chk({tag, " R6 outputs on in ramp"}, out_en, 1);
        chk({tag, " R6 ramp step"}, duty, k - 56);
        if (k == 59) begin
          idle(10);
          chk({tag, " R10 ramp holds between strobes"}, duty, 3);
        end
      end else begin
        chk({tag, " R7 full step in run"}, duty, 7);
        chk({tag, " R7 outputs on in run"}, out_en, 1);
        chk({tag, " R7 sync on in run"}, sync_en, 1);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b0; sup_ok = 1'b0; ovc = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk("R1 reset out_en", out_en, 0);
    chk("R1 reset sync_en", sync_en, 0);
    chk("R1 reset step", duty, 0);
    strobe();
    chk("R1 strobes without supply keep off", sync_en, 0);
  endtask

  task automatic t_power_up();
    @(negedge clk);
    sup_ok = 1'b1;
    idle(1);
    run_seq("power-up", 20);
  endtask

  task automatic fault_pulse(input int len);
    @(negedge clk);
    ovc = 1'b1;
    #1;
    chk("R2 out_en cut same cycle", out_en, 0);
    chk("R2 sync_en cut same cycle", sync_en, 0);
    idle(len);
    ovc = 1'b0;
    idle(4);
  endtask

  task automatic t_fault_run();
    fault_pulse(5);
    chk("R9 step zero after fault", duty, 0);
    chk("R3 sync off after fault", sync_en, 0);
    run_seq("fault-in-run", 0);
  endtask

  task automatic t_fault_hold();
    fault_pulse(5);
    for (int k = 0; k < 30; k++) strobe();
    chk("R4 still off at 30 strobes", sync_en, 0);
    fault_pulse(3);
    run_seq("R4 fault-in-hold", 0);
  endtask

  task automatic t_fault_lead();
    fault_pulse(4);
    for (int k = 0; k < 56; k++) strobe();
    chk("R5 lead-in reached", sync_en, 1);
    fault_pulse(4);
    chk("R4 lead-in fault step zero", duty, 0);
    run_seq("fault-in-lead", 0);
  endtask

  task automatic t_supply_drop();
    fault_pulse(4);
    for (int k = 0; k < 60; k++) strobe();
    chk("R6 mid-ramp step", duty, 4);
    @(negedge clk);
    sup_ok = 1'b0;
    #1;
    chk("R8 out_en cut on supply loss", out_en, 0);
    chk("R8 sync_en cut on supply loss", sync_en, 0);
    idle(2);
    chk("R8 step zero while supply low", duty, 0);
    strobe();
    chk("R8 strobes ignored while supply low", sync_en, 0);
    @(negedge clk);
    sup_ok = 1'b1;
    idle(1);
    run_seq("R8 supply-return", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_power_up();
    t_fault_run();
    t_fault_hold();
    t_fault_lead();
    t_supply_drop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule